// File: doc/BRIEF.md
# Current-Limit Undervoltage Fault Response Timer

This block decides what happens to a regulator's power stage when an undervoltage condition is flagged while the converter is running in current limit. A synchronous fault flag, an enable command and a one-byte configuration word come in. A power-stage enable and two status flags go out. Depending on the configuration, the fault is either passed over or timed for a selectable qualification window. A qualified fault then either shuts the stage down until the enable is cycled, or starts an endless series of fixed-interval restart attempts.

A microsecond timebase comes from a prescaler on the system clock. The prescaler runs only while a timing window is open, so every window is an exact number of clock cycles long. One counter serves both the qualification delay and the restart interval. The configuration byte reads back in a fixed layout. A write that carries an unsupported retry code is refused as a whole and raises a one-cycle invalid-data pulse.

Top module: `ocuv_fault_responder`

## Requirements
- R1: After reset the power-stage enable, the sticky fault flag and the invalid-data pulse are all 0, and the configuration byte reads 8'h40 (ignore bit 1, delay code 00, latch-off).
- R2: The configuration byte reads back as bit 7 = 0, bit 6 = ignore bit, bits 5:3 = the stored retry mode repeated three times, bit 2 = 0, and bits 1:0 = delay code. Written values of bits 7 and 2 are dropped.
- R3: A write whose bits 5:3 are neither 000 nor 111 leaves the whole configuration unchanged and drives the invalid-data output high for the one cycle that follows the write edge. Valid writes keep that output low.
- R4: With the enable input sampled high in the off state, the power-stage enable rises at that edge. An edge that samples the enable input low forces the power-stage enable to 0.
- R5: With bit 6 = 0 (active-low ignore), the fault input leaves the power-stage enable and the sticky flag untouched. Clearing bit 6 during a qualification window abandons that window.
- R6: With bit 6 = 1, a persistent fault drops the power-stage enable exactly D x TICK_DIV clock edges after the edge that first samples it. D is 2, 16, 64 or 256 for delay codes 00, 01, 10 and 11.
- R7: A fault that disappears before the window expires leaves the output enabled and resets the count, so the next fault needs the full window again.
- R8: With retry mode 000, a qualified fault keeps the output off after the fault clears, until the enable input is driven low and then high.
- R9: With retry mode 111, the output is re-enabled exactly HICCUP_US x TICK_DIV clock edges after a trip. A fault that is still present is then qualified again over the full window, with no limit on the number of attempts.
- R10: Every qualified trip sets the sticky fault flag. A pulse on the clear input resets it, and a trip wins over a clear in the same cycle.
- R11: Driving the enable input low during a restart interval cancels the restart, and the output stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Conversion enable command |
| fault_i | input | 1 | Synchronous undervoltage-in-current-limit flag |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write byte |
| clr_i | input | 1 | Clear pulse for the sticky fault flag |
| pwr_en_o | output | 1 | Power-stage enable |
| flt_sticky_o | output | 1 | Sticky qualified-fault flag |
| ivd_o | output | 1 | One-cycle invalid-data pulse |
| cfg_rd_o | output | 8 | Configuration byte view |

## Verification
The hardest situation to reach is the second and later restart attempts in the endless retry mode. Reaching them needs a fault held across a full trip, a full restart interval and a fresh qualification window, all with cycle-exact edges. The stimulus holds the fault and counts clock edges from the first trip through two restarts. It then pulls the enable low in the middle of a restart interval. A bench parameter shortens the restart interval so that this whole sequence stays short, while the timebase keeps its default division.

// File: rtl/ocuv_pkg.sv
package ocuv_pkg;

   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_RUN    = 3'd1,
      ST_QUAL   = 3'd2,
      ST_LATCH  = 3'd3,
      ST_HICCUP = 3'd4
   } resp_state_e;

   typedef struct packed {
      logic       ign_n;   // 0: fault passed over
      logic       rmode;   // 0: latch-off, 1: endless restart
      logic [1:0] dly;     // qualification window code
   } resp_cfg_t;

   localparam resp_cfg_t CFG_RESET = '{ign_n: 1'b1, rmode: 1'b0, dly: 2'b00};
   localparam int unsigned DLY_MAX_US = 256;

   // qualification window length in microseconds for a delay code
   function automatic int unsigned dly_us(input logic [1:0] code);
      case (code)
         2'b00:   return 2;
         2'b01:   return 16;
         2'b10:   return 64;
         default: return 256;
      endcase
   endfunction

endpackage

// File: rtl/ocuv_cfg_reg.sv
module ocuv_cfg_reg
   import ocuv_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [7:0]       wdata_i,
   output resp_cfg_t        cfg_o,
   output logic [7:0]       rdata_o,
   output logic             ivd_o
);

   logic [2:0] retry_code;
   logic       code_ok;
   logic       unused_wbits;

   assign retry_code   = wdata_i[5:3];
   assign code_ok      = (retry_code == 3'b000) || (retry_code == 3'b111);
   assign unused_wbits = ^{wdata_i[7], wdata_i[2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_o <= CFG_RESET;
         ivd_o <= 1'b0;
      end else begin
         ivd_o <= wr_i && !code_ok;
         if (wr_i && code_ok) begin
            cfg_o.ign_n <= wdata_i[6];
            cfg_o.rmode <= wdata_i[3];
            cfg_o.dly   <= wdata_i[1:0];
         end
      end
   end

   assign rdata_o = {1'b0, cfg_o.ign_n, {3{cfg_o.rmode}}, 1'b0, cfg_o.dly};

endmodule

// File: rtl/ocuv_timebase.sv
module ocuv_timebase #(
   parameter int unsigned TICK_DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);

   generate
      if (TICK_DIV == 1) begin : g_direct
         assign tick_o = run_i;
      end else begin : g_presc
         localparam int unsigned PW = $clog2(TICK_DIV);
         localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre_q <= '0;
            else if (!run_i || pre_q == LAST)
               pre_q <= '0;
            else
               pre_q <= pre_q + 1'b1;
         end

         assign tick_o = run_i && (pre_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/ocuv_timer.sv
module ocuv_timer
   import ocuv_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned HICCUP_US = 52000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_i,
   input  logic       tick_i,
   input  logic       sel_hiccup_i,
   input  logic [1:0] dly_code_i,
   output logic       done_o
);

   localparam logic [CNT_W-1:0] HIC_LAST = CNT_W'(HICCUP_US - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_val;

   assign last_val = sel_hiccup_i ? HIC_LAST : CNT_W'(dly_us(dly_code_i) - 1);
   assign done_o   = run_i && tick_i && (cnt_q == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run_i || done_o)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/ocuv_ctrl.sv
module ocuv_ctrl
   import ocuv_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic fault_i,
   input  logic ign_n_i,
   input  logic rmode_i,
   input  logic done_i,
   input  logic clr_i,
   output logic run_o,
   output logic sel_hiccup_o,
   output logic pwr_en_o,
   output logic sticky_o
);

   resp_state_e state_q, state_d;
   logic        trip;

   assign trip = (state_q == ST_QUAL) && en_i && fault_i && ign_n_i && done_i;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_OFF:    if (en_i) state_d = ST_RUN;
         ST_RUN: begin
            if (!en_i)                 state_d = ST_OFF;
            else if (fault_i && ign_n_i) state_d = ST_QUAL;
         end
         ST_QUAL: begin
            if (!en_i)                   state_d = ST_OFF;
            else if (!fault_i || !ign_n_i) state_d = ST_RUN;
            else if (done_i)             state_d = rmode_i ? ST_HICCUP : ST_LATCH;
         end
         ST_LATCH:  if (!en_i) state_d = ST_OFF;
         ST_HICCUP: begin
            if (!en_i)       state_d = ST_OFF;
            else if (done_i) state_d = ST_RUN;
         end
         default:   state_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_OFF;
         sticky_o <= 1'b0;
      end else begin
         state_q <= state_d;
         if (trip)
            sticky_o <= 1'b1;
         else if (clr_i)
            sticky_o <= 1'b0;
      end
   end

   assign run_o        = (state_q == ST_QUAL) || (state_q == ST_HICCUP);
   assign sel_hiccup_o = (state_q == ST_HICCUP);
   assign pwr_en_o     = (state_q == ST_RUN) || (state_q == ST_QUAL);

endmodule

// File: rtl/ocuv_fault_responder.sv
module ocuv_fault_responder
   import ocuv_pkg::*;
#(
   parameter int unsigned TICK_DIV  = 50,
   parameter int unsigned HICCUP_US = 52000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       fault_i,
   input  logic       cfg_wr_i,
   input  logic [7:0] cfg_wdata_i,
   input  logic       clr_i,
   output logic       pwr_en_o,
   output logic       flt_sticky_o,
   output logic       ivd_o,
   output logic [7:0] cfg_rd_o
);

   localparam int unsigned CNT_MAX = (HICCUP_US > DLY_MAX_US) ? HICCUP_US : DLY_MAX_US;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (HICCUP_US < 1) begin : g_bad_hic
         $error("HICCUP_US must be at least 1");
      end
   endgenerate

   resp_cfg_t cfg;
   logic      run, tick, done, sel_hiccup;

   ocuv_cfg_reg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cfg_wr_i),
      .wdata_i (cfg_wdata_i),
      .cfg_o   (cfg),
      .rdata_o (cfg_rd_o),
      .ivd_o   (ivd_o)
   );

   ocuv_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .tick_o (tick)
   );

   ocuv_timer #(.CNT_W(CNT_W), .HICCUP_US(HICCUP_US)) u_tmr (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_i        (run),
      .tick_i       (tick),
      .sel_hiccup_i (sel_hiccup),
      .dly_code_i   (cfg.dly),
      .done_o       (done)
   );

   ocuv_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (en_i),
      .fault_i      (fault_i),
      .ign_n_i      (cfg.ign_n),
      .rmode_i      (cfg.rmode),
      .done_i       (done),
      .clr_i        (clr_i),
      .run_o        (run),
      .sel_hiccup_o (sel_hiccup),
      .pwr_en_o     (pwr_en_o),
      .sticky_o     (flt_sticky_o)
   );

endmodule

// File: rtl/ocuv_fault_responder_chk.sv
module ocuv_fault_responder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en_i,
   input logic       pwr_en_o,
   input logic       flt_sticky_o,
   input logic       ivd_o,
   input logic [7:0] cfg_rd_o
);

   AST_RDATA_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd_o[7] && !cfg_rd_o[2] && (cfg_rd_o[5:3] == 3'b000 || cfg_rd_o[5:3] == 3'b111)); // R2

   AST_IVD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ivd_o |-> $stable(cfg_rd_o)); // R3

   AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_i) == 1'b0) |-> !pwr_en_o); // R4

   AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en_o) |-> $past(en_i)); // R4

   AST_IGNORED_KEEPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_rd_o[6]) && $past(en_i) && $past(pwr_en_o)) |-> pwr_en_o); // R5

   AST_TRIP_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pwr_en_o) && $past(en_i)) |-> flt_sticky_o); // R10

endmodule

bind ocuv_fault_responder ocuv_fault_responder_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .en_i         (en_i),
   .pwr_en_o     (pwr_en_o),
   .flt_sticky_o (flt_sticky_o),
   .ivd_o        (ivd_o),
   .cfg_rd_o     (cfg_rd_o)
);

// File: tb/test_ocuv_fault_responder.sv
`timescale 1ns/1ps
module test_ocuv_fault_responder;

   localparam int DIV = 50;
   localparam int HIC = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b0;
   logic       fault_i = 1'b0;
   logic       cfg_wr_i = 1'b0;
   logic [7:0] cfg_wdata_i = 8'h00;
   logic       clr_i = 1'b0;
   logic       pwr_en_o, flt_sticky_o, ivd_o;
   logic [7:0] cfg_rd_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   ocuv_fault_responder #(.TICK_DIV(DIV), .HICCUP_US(HIC)) i_ocuv_fault_responder (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (en_i),
      .fault_i      (fault_i),
      .cfg_wr_i     (cfg_wr_i),
      .cfg_wdata_i  (cfg_wdata_i),
      .clr_i        (clr_i),
      .pwr_en_o     (pwr_en_o),
      .flt_sticky_o (flt_sticky_o),
      .ivd_o        (ivd_o),
      .cfg_rd_o     (cfg_rd_o)
   );

   // {write byte, expected readback, expected invalid pulse}
   localparam logic [16:0] CFG_VEC [8] = '{
      {8'h00, 8'h00, 1'b0},
      {8'h7B, 8'h7B, 1'b0},
      {8'h50, 8'h7B, 1'b1},
      {8'hFF, 8'h7B, 1'b0},
      {8'h8D, 8'h7B, 1'b1},
      {8'h39, 8'h39, 1'b0},
      {8'h46, 8'h42, 1'b0},
      {8'h68, 8'h42, 1'b1}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_cfg(input logic [7:0] d);
      cfg_wr_i = 1'b1;
      cfg_wdata_i = d;
      step(1);
      cfg_wr_i = 1'b0;
   endtask

   task automatic restart_en();
      en_i = 1'b0;
      step(1);
      en_i = 1'b1;
      step(1);
   endtask

   task automatic clear_sticky();
      clr_i = 1'b1;
      step(1);
      clr_i = 1'b0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk("R1 pwr_en", pwr_en_o, 0);
      chk("R1 sticky", flt_sticky_o, 0);
      chk("R1 ivd", ivd_o, 0);
      chk("R1 readback", cfg_rd_o, 8'h40);

      // R2 / R3 table of configuration writes
      for (int i = 0; i < 8; i++) begin
         wr_cfg(CFG_VEC[i][16:9]);
         chk("R2 readback", cfg_rd_o, CFG_VEC[i][8:1]);
         chk("R3 ivd", ivd_o, CFG_VEC[i][0]);
      end
      step(1);
      chk("R3 ivd one cycle", ivd_o, 0);

      // R4 enable
      en_i = 1'b1;
      step(1);
      chk("R4 enable rise", pwr_en_o, 1);

      // R6 window per code, R8 latch-off, R10 sticky
      for (int c = 0; c < 4; c++) begin
         int d;
         d = (c == 0) ? 2 : (c == 1) ? 16 : (c == 2) ? 64 : 256;
         wr_cfg({1'b0, 1'b1, 3'b000, 1'b0, 2'(c)});
         fault_i = 1'b1;
         step(d * DIV);
         chk("R6 still on at window end", pwr_en_o, 1);
         step(1);
         chk("R6 off after window", pwr_en_o, 0);
         chk("R10 sticky set", flt_sticky_o, 1);
         fault_i = 1'b0;
         step(20);
         chk("R8 latched off", pwr_en_o, 0);
         clear_sticky();
         chk("R10 sticky cleared", flt_sticky_o, 0);
         en_i = 1'b0;
         step(1);
         chk("R4 off while disabled", pwr_en_o, 0);
         en_i = 1'b1;
         step(1);
         chk("R8 re-enable after toggle", pwr_en_o, 1);
      end

      // R7 early fault removal resets the window
      wr_cfg(8'h40);
      fault_i = 1'b1;
      step(60);
      fault_i = 1'b0;
      step(5);
      chk("R7 stays on after short fault", pwr_en_o, 1);
      fault_i = 1'b1;
      step(2 * DIV);
      chk("R7 full window needed again", pwr_en_o, 1);
      step(1);
      chk("R7 trip after full window", pwr_en_o, 0);
      fault_i = 1'b0;
      restart_en();
      clear_sticky();

      // R5 ignore bit active low
      wr_cfg(8'h01);
      fault_i = 1'b1;
      step(1000);
      chk("R5 ignored fault keeps on", pwr_en_o, 1);
      chk("R5 ignored fault no sticky", flt_sticky_o, 0);
      fault_i = 1'b0;
      step(2);
      wr_cfg(8'h41);
      fault_i = 1'b1;
      step(400);
      wr_cfg(8'h01);
      step(1000);
      chk("R5 ignore mid-window abandons", pwr_en_o, 1);
      fault_i = 1'b0;
      step(2);

      // R9 endless restart
      wr_cfg(8'h78);
      fault_i = 1'b1;
      step(2 * DIV);
      chk("R9 on before trip", pwr_en_o, 1);
      step(1);
      chk("R9 tripped", pwr_en_o, 0);
      step(HIC * DIV - 1);
      chk("R9 still off in interval", pwr_en_o, 0);
      step(1);
      chk("R9 first restart", pwr_en_o, 1);
      step(2 * DIV);
      chk("R9 requalify full window", pwr_en_o, 1);
      step(1);
      chk("R9 second trip", pwr_en_o, 0);
      step(HIC * DIV);
      chk("R9 second restart", pwr_en_o, 1);
      clear_sticky();
      step(50);
      step(51);
      chk("R9 third trip", pwr_en_o, 0);
      chk("R10 sticky on restart trip", flt_sticky_o, 1);

      // R11 disable cancels the restart
      en_i = 1'b0;
      step(HIC * DIV + 200);
      chk("R11 no restart when disabled", pwr_en_o, 0);
      fault_i = 1'b0;
      en_i = 1'b1;
      step(1);
      chk("R11 enable again", pwr_en_o, 1);

      summary();
   end

endmodule